// File: doc/BRIEF.md
# Byte-to-Word ATA Data Port Bridge

This block connects an 8-bit processor I/O bus to a drive whose data register is 16 bits wide. It looks only at the low byte of the I/O address. It recognises the eight ATA command-block registers, which sit in the pattern `101rrr11`, where `rrr` is the register index. All registers except the data register are passed straight through as single byte transfers. The data register sits at index 0, which is address A3h. For that register the bridge turns each pair of byte accesses into one word transfer. A two-phase toggle, named first-byte and second-byte, tracks where the bridge is within a pair. On the first read of a pair the drive is read as a whole word. The low byte goes to the processor and the high byte is parked in a holding latch. The second read returns the parked byte and does not touch the drive. For writes, the first byte is only stored. The second byte triggers one word write, with the stored byte as the low half.

A read or write of any other ATA register puts the toggle back to first-byte. So does a write or read of the card's control port at E3h. Any other I/O address leaves the toggle as it is. Reset sets the toggle to first-byte.

Strobes are sampled on the clock and act on their rising edge. The transfer engine is a five-state machine:
- `ST_IDLE` waits for a strobe edge.
- `ST_WORD_RD` drives a word read and captures the result.
- `ST_WORD_WR` drives a word write.
- `ST_BYTE_RD` drives a pass-through read.
- `ST_BYTE_WR` drives a pass-through write.

The transitions are:
- `idle->word_rd`: first-byte data read.
- `idle->word_wr`: second-byte data write.
- `idle->byte_rd`: non-data register read.
- `idle->byte_wr`: non-data register write.
- `idle->idle`: a second-byte read, a first-byte write, a control-port access or a foreign address; these take no device cycle.
- `busy->idle`: from any of the four transfer states, after one cycle.

Top module: `ata_byte_bridge`

## Requirements
- R1: Only addresses whose bits are `101xxx11` produce a device access. `ata_sel` equals address bits 4..2. Any other address produces no device strobe.
- R2: A data-port (A3h) read in the first-byte phase issues exactly one one-cycle `ata_rd` with `ata_sel`=0. `cpu_rdata` then holds bits 7..0 of the word returned, and bits 15..8 are kept. The phase becomes second-byte.
- R3: A data-port read in the second-byte phase issues no `ata_rd`. `cpu_rdata` then holds the kept high byte, and the phase becomes first-byte.
- R4: A data-port write in the first-byte phase issues no `ata_wr`. It stores the byte, and the phase becomes second-byte.
- R5: A data-port write in the second-byte phase issues one one-cycle `ata_wr` with `ata_sel`=0. `ata_wdata` is {new byte, stored byte}, and the phase becomes first-byte.
- R6: A read or write of a non-data ATA register, or of E3h, leaves the phase at first-byte.
- R7: A read or write of any address that is neither an ATA register nor E3h leaves the phase unchanged.
- R8: A non-data register read issues one `ata_rd` with `ata_sel`=rrr, and `cpu_rdata` gets `ata_rdata[7:0]`. A non-data register write issues one `ata_wr` with `ata_wdata`={8'h00, byte}.
- R9: While reset is asserted, and after it is released, the phase is first-byte, no strobe is driven and `cpu_rdata` is 0.
- R10: A strobe held high for many cycles counts as one access: one device pulse at most, and one phase step.
- R11: `ata_rd` and `ata_wr` are never high in the same cycle, and `ata_sel` does not change in the cycle after a device read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 8 | Low byte of the processor I/O address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rd | input | 1 | Processor I/O read strobe, level |
| cpu_wr | input | 1 | Processor I/O write strobe, level |
| cpu_rdata | output | 8 | Byte returned to the processor |
| ata_sel | output | 3 | Command-block register index |
| ata_rd | output | 1 | One-cycle device read pulse |
| ata_wr | output | 1 | One-cycle device write pulse |
| ata_wdata | output | 16 | Word driven to the device |
| ata_rdata | input | 16 | Word returned by the device during `ata_rd` |

## Verification
Every one of the 256 low-byte addresses is read and written while the bridge sits in the second-byte phase. A data-port access then follows, and the device pulse count shows whether the access resynchronised the toggle (R6) or left it alone (R7). Runs of data reads and writes, some back to back and some crossed between reads and writes, check that each pair produces exactly one word transfer with the halves in the right order. A strobe held for many cycles checks that edge detection counts it as one access rather than several.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int IDX_W  = 3;
    localparam logic [BYTE_W-1:0] CTRL_PORT = 8'hE3;
    localparam logic [IDX_W-1:0]  DATA_IDX  = '0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WORD_RD,
        ST_WORD_WR,
        ST_BYTE_RD,
        ST_BYTE_WR
    } xfer_state_t;

    typedef enum logic {
        PH_FIRST,
        PH_SECOND
    } pair_phase_t;

    typedef struct packed {
        logic             ata_hit;
        logic             data_hit;
        logic             ctrl_hit;
        logic [IDX_W-1:0] idx;
    } port_dec_t;
endpackage

// File: rtl/ata_port_decode.sv
module ata_port_decode
    import ata_bridge_pkg::*;
(
    input  logic [BYTE_W-1:0] addr,
    output port_dec_t         dec
);
    always_comb begin
        dec.ata_hit  = (addr[7:5] == 3'b101) && (addr[1:0] == 2'b11);
        dec.idx      = addr[4:2];
        dec.data_hit = dec.ata_hit && (addr[4:2] == DATA_IDX);
        dec.ctrl_hit = (addr == CTRL_PORT);
    end
endmodule

// File: rtl/ata_strobe_edge.sv
module ata_strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_edge
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q;
    end
endmodule

// File: rtl/ata_pair_phase.sv
module ata_pair_phase
    import ata_bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    input  logic        resync,
    output pair_phase_t phase
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      phase <= PH_FIRST;
        else if (resync) phase <= PH_FIRST;
        else if (step)   phase <= (phase == PH_FIRST) ? PH_SECOND : PH_FIRST;
    end
endmodule

// File: rtl/ata_byte_bridge.sv
module ata_byte_bridge
    import ata_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic [IDX_W-1:0]  ata_sel,
    output logic              ata_rd,
    output logic              ata_wr,
    output logic [WORD_W-1:0] ata_wdata,
    input  logic [WORD_W-1:0] ata_rdata
);
    port_dec_t   dec;
    logic [1:0]  rise;
    pair_phase_t phase;
    xfer_state_t state_q, state_d;

    logic [BYTE_W-1:0] rdata_q, hold_q, low_q;
    logic [IDX_W-1:0]  sel_q;
    logic [WORD_W-1:0] wdata_q;

    logic accept, do_rd, do_wr, step, resync;

    ata_port_decode u_dec (.addr(cpu_addr), .dec(dec));

    ata_strobe_edge #(.N(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl({cpu_wr, cpu_rd}), .rise(rise)
    );

    assign accept = (state_q == ST_IDLE) && (rise[0] || rise[1]);
    assign do_rd  = accept && rise[0];
    assign do_wr  = accept && !rise[0] && rise[1];
    assign step   = accept && dec.data_hit;
    assign resync = accept && ((dec.ata_hit && !dec.data_hit) || dec.ctrl_hit);

    ata_pair_phase u_phase (
        .clk(clk), .rst_n(rst_n), .step(step), .resync(resync), .phase(phase)
    );

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (do_rd && dec.ata_hit) begin
                    if (!dec.data_hit)           state_d = ST_BYTE_RD;
                    else if (phase == PH_FIRST)  state_d = ST_WORD_RD;
                end else if (do_wr && dec.ata_hit) begin
                    if (!dec.data_hit)           state_d = ST_BYTE_WR;
                    else if (phase == PH_SECOND) state_d = ST_WORD_WR;
                end
            end
            ST_WORD_RD, ST_WORD_WR, ST_BYTE_RD, ST_BYTE_WR: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            hold_q  <= '0;
            low_q   <= '0;
            sel_q   <= '0;
            wdata_q <= '0;
        end else begin
            if (accept && dec.ata_hit) sel_q <= dec.idx;
            if (do_rd && dec.data_hit && phase == PH_SECOND) rdata_q <= hold_q;
            if (do_wr && dec.data_hit) begin
                if (phase == PH_FIRST) low_q   <= cpu_wdata;
                else                   wdata_q <= {cpu_wdata, low_q};
            end
            if (do_wr && dec.ata_hit && !dec.data_hit)
                wdata_q <= {{BYTE_W{1'b0}}, cpu_wdata};
            if (state_q == ST_WORD_RD) begin
                rdata_q <= ata_rdata[BYTE_W-1:0];
                hold_q  <= ata_rdata[WORD_W-1:BYTE_W];
            end
            if (state_q == ST_BYTE_RD) rdata_q <= ata_rdata[BYTE_W-1:0];
        end
    end

    // outputs
    always_comb begin
        ata_rd    = (state_q == ST_WORD_RD) || (state_q == ST_BYTE_RD);
        ata_wr    = (state_q == ST_WORD_WR) || (state_q == ST_BYTE_WR);
        ata_sel   = sel_q;
        ata_wdata = wdata_q;
        cpu_rdata = rdata_q;
    end
endmodule

// File: rtl/ata_byte_bridge_checker.sv
module ata_byte_bridge_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cpu_addr,
    input logic       cpu_rd,
    input logic       ata_rd,
    input logic       ata_wr,
    input logic [2:0] ata_sel
);
    logic addr_hit;
    assign addr_hit = (cpu_addr[7:5] == 3'b101) && (cpu_addr[1:0] == 2'b11);

    assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ata_rd && ata_wr));

    assert_sel_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ata_rd |=> $stable(ata_sel));

    assert_rd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ata_rd |=> !ata_rd);

    assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ata_wr |=> !ata_wr);

    assert_offcard_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_rd) && !addr_hit) |=> !ata_rd);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!ata_rd && !ata_wr));
endmodule

bind ata_byte_bridge ata_byte_bridge_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .ata_rd(ata_rd), .ata_wr(ata_wr), .ata_sel(ata_sel)
);

// File: tb/tb_ata_byte_bridge.sv
module tb_ata_byte_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [2:0]  ata_sel;
    logic        ata_rd, ata_wr;
    logic [15:0] ata_wdata, ata_rdata;

    int compared = 0, mismatched = 0;
    int rd_cnt = 0, wr_cnt = 0, both_cnt = 0, cycles = 0;
    int dev_ptr = 0;
    logic [15:0] seen_wdata = '0;
    logic [2:0]  seen_sel = '0;

    // bench model state
    bit          m_second = 0;
    int          m_ptr = 0;
    logic [7:0]  m_hold = '0, m_low = '0;

    always #4 clk = ~clk;

    ata_byte_bridge dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .ata_sel(ata_sel), .ata_rd(ata_rd), .ata_wr(ata_wr),
        .ata_wdata(ata_wdata), .ata_rdata(ata_rdata)
    );

    function automatic logic [15:0] word_of(int p);
        logic [7:0] hi, lo;
        hi = 8'(p * 7 + 8'h31);
        lo = 8'(p * 13 + 5);
        return {hi, lo};
    endfunction

    assign ata_rdata = (ata_sel == 3'd0) ? word_of(dev_ptr)
                                         : {8'hEE, 8'h40 + {5'd0, ata_sel}};

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (ata_rd) begin
            rd_cnt <= rd_cnt + 1;
            if (ata_sel == 3'd0) dev_ptr <= dev_ptr + 1;
        end
        if (ata_wr) begin
            wr_cnt     <= wr_cnt + 1;
            seen_wdata <= ata_wdata;
            seen_sel   <= ata_sel;
        end
        if (ata_rd && ata_wr) both_cnt <= both_cnt + 1;
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog R1..all act=%0d exp<150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit is_ata(logic [7:0] a);
        return (a >> 5) == 3'd5 && (a % 4) == 3;
    endfunction

    task automatic do_read(logic [7:0] a, int hold_cyc, string tag);
        int r0 = rd_cnt;
        int exp_pulses = 0;
        int exp_data = -1;
        logic [15:0] w;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        repeat (hold_cyc) @(negedge clk);
        if (a == 8'hA3) begin
            if (!m_second) begin
                w = word_of(m_ptr); m_ptr++; m_hold = w[15:8];
                exp_data = w[7:0]; exp_pulses = 1; m_second = 1;
            end else begin
                exp_data = m_hold; m_second = 0;
            end
        end else if (is_ata(a)) begin
            exp_pulses = 1; exp_data = 8'h40 + ((a >> 2) % 8); m_second = 0;
        end else if (a == 8'hE3) m_second = 0;
        check({tag, " rd pulses"}, rd_cnt - r0, exp_pulses);
        if (exp_data >= 0) check({tag, " rd data"}, cpu_rdata, exp_data);
        cpu_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] v, string tag);
        int w0 = wr_cnt;
        int exp_pulses = 0;
        int exp_word = 0;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1;
        repeat (2) @(negedge clk);
        if (a == 8'hA3) begin
            if (!m_second) begin m_low = v; m_second = 1; end
            else begin exp_pulses = 1; exp_word = {v, m_low}; m_second = 0; end
        end else if (is_ata(a)) begin
            exp_pulses = 1; exp_word = {8'h00, v}; m_second = 0;
        end else if (a == 8'hE3) m_second = 0;
        check({tag, " wr pulses"}, wr_cnt - w0, exp_pulses);
        if (exp_pulses == 1) begin
            check({tag, " wr word"}, seen_wdata, exp_word);
            check({tag, " wr sel"}, seen_sel, int'((a >> 2) % 8));
        end
        cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset rdata", cpu_rdata, 0);
        check("R9 reset strobes", int'(ata_rd) + int'(ata_wr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 post-reset strobes", rd_cnt + wr_cnt, 0);
        do_read(8'hA3, 2, "R9 R2 first read after reset");
        do_read(8'hA3, 2, "R3 second read");

        // read sweep: every address probed in the second-byte phase
        for (int a = 0; a < 256; a++) begin
            if (a == 8'hA3) continue;
            do_read(8'hA3, 2, "R2 pair start");
            do_read(8'(a), 2, is_ata(8'(a)) ? "R1 R6 R8 ata rd" :
                               (a == 8'hE3 ? "R6 ctrl rd" : "R1 R7 foreign rd"));
            do_read(8'hA3, 2, "R6 R7 phase probe");
            if (m_second) do_read(8'hA3, 2, "R3 realign");
        end

        // write sweep
        for (int a = 0; a < 256; a++) begin
            if (a == 8'hA3) continue;
            do_write(8'hA3, 8'(a ^ 8'h5A), "R4 first write");
            do_write(8'(a), 8'(a), is_ata(8'(a)) ? "R6 R8 ata wr" :
                                    (a == 8'hE3 ? "R6 ctrl wr" : "R7 foreign wr"));
            do_write(8'hA3, 8'(a + 1), "R5 R6 R7 phase probe");
            if (m_second) do_write(8'hA3, 8'hC3, "R5 realign");
        end

        // back-to-back pairs and crossed read/write
        for (int i = 0; i < 8; i++) begin
            do_write(8'hA3, 8'(i * 17), "R4 burst");
            do_write(8'hA3, 8'(i * 29 + 3), "R5 burst");
            do_read(8'hA3, 2, "R2 burst");
            do_read(8'hA3, 2, "R3 burst");
        end
        do_read(8'hA3, 2, "R2 cross");
        do_write(8'hA3, 8'h77, "R5 cross after read");

        // held strobe counts once
        do_read(8'hA3, 12, "R10 held read");
        do_read(8'hA3, 12, "R10 held second");
        do_read(8'hBF, 12, "R10 R8 held status");

        check("R11 rd/wr overlap cycles", both_cnt, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule